// File: doc/BRIEF.md
# Decimal Digit Counter with Segment Drive

This block keeps a single decimal digit that steps from 0 up to 9 and back to 0 on each rising clock edge. It turns the digit straight into active-high segment levels for a common-cathode seven-segment display. A synchronous reset returns the digit to 0. A freeze input makes the counter ignore clock edges. A display-enable input blanks the segments without touching the count.

Three side outputs help when digits are chained or decoded:
- A registered copy of the display enable, one clock late.
- A square wave at one tenth of the count rate, high for the lower half of the digit range. Its falling-to-rising transition marks the wrap, so it can drive the next digit's clock.
- An active-low flag that goes low only while the digit is 2.

Top module: `decade_seg_counter`

## Requirements
- R1: When `rst` and `freeze` are both low, each rising clock edge adds one to the digit, and the digit goes from 9 to 0.
- R2: When `rst` is high at a rising edge, the digit becomes 0 after that edge. This happens whatever the level of `freeze`.
- R3: When `freeze` is high and `rst` is low, a rising edge leaves the digit unchanged.
- R4: `seg` carries segment a in bit 0 through segment g in bit 6, and a 1 lights the segment. The digits 0 to 9 give 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F. So 6 lights segment a and 9 lights segment d.
- R5: While `disp_on` is low, `seg` is 0x00. The digit keeps counting, and the correct pattern appears as soon as `disp_on` returns high.
- R6: `disp_on_q` shows the value `disp_on` had at the previous rising edge. It is 0 after any edge where `rst` is high.
- R7: `div10` is 1 while the digit is 0 to 4 and 0 while it is 5 to 9.
- R8: `not_two` is 0 while the digit is 2 and 1 for every other digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the digit changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the digit |
| freeze | input | 1 | High: clock edges leave the digit unchanged |
| disp_on | input | 1 | High: segments shown; low: all segments off |
| seg | output | 7 | Segment levels, bit 0 = a through bit 6 = g |
| disp_on_q | output | 1 | `disp_on` delayed by one clock |
| div10 | output | 1 | High for digits 0 to 4 |
| not_two | output | 1 | Low only while the digit is 2 |

## Verification
The digit register and `disp_on_q` are the only state. Each of them takes a new value at the rising edge where its inputs were sampled. `seg`, `div10` and `not_two` then follow that digit combinationally in the same cycle. The only exception is blanking: `seg` reacts to `disp_on` with no clock at all.

The bench changes inputs on the falling edge. It updates its own digit model at the rising edge and compares every output one time unit after that edge. It sweeps all ten digits through several wraps, with both `disp_on` levels and combinations of freeze and reset.

// File: rtl/seg_counter_pkg.sv
package seg_counter_pkg;

    localparam int DIGITS = 10;
    localparam int CNT_W  = $clog2(DIGITS);

    typedef logic [CNT_W-1:0] digit_t;

    typedef struct packed {
        logic g;
        logic f;
        logic e;
        logic d;
        logic c;
        logic b;
        logic a;
    } seg_t;

    localparam seg_t SEG_OFF = '0;

    function automatic seg_t digit_to_seg(input digit_t v);
        seg_t s;
        s = SEG_OFF;
        case (v)
            digit_t'(0): s = 7'h3F;
            digit_t'(1): s = 7'h06;
            digit_t'(2): s = 7'h5B;
            digit_t'(3): s = 7'h4F;
            digit_t'(4): s = 7'h66;
            digit_t'(5): s = 7'h6D;
            digit_t'(6): s = 7'h7D;
            digit_t'(7): s = 7'h07;
            digit_t'(8): s = 7'h7F;
            digit_t'(9): s = 7'h6F;
            default:     s = SEG_OFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/digit_counter.sv
module digit_counter
    import seg_counter_pkg::*;
#(
    parameter int MODULUS = DIGITS
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   freeze,
    output digit_t cnt
);
    localparam digit_t LAST = digit_t'(MODULUS - 1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (!freeze)
            cnt <= (cnt == LAST) ? '0 : cnt + digit_t'(1);
    end

    // R2
    reset_clears_chk: assert property (@(posedge clk) rst |=> cnt == '0);

    // R1
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!freeze && cnt == LAST) |=> cnt == '0);

    // R1
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (!freeze && cnt != LAST) |=> cnt == $past(cnt) + digit_t'(1));

    // R3
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(cnt));

endmodule

// File: rtl/seg_encoder.sv
module seg_encoder
    import seg_counter_pkg::*;
(
    input  digit_t cnt,
    input  logic   disp_on,
    output seg_t   seg
);
    seg_t pattern;

    always_comb begin
        pattern = digit_to_seg(cnt);
        seg     = disp_on ? pattern : SEG_OFF;
    end

    // R4
    always_comb begin
        if (disp_on && cnt < digit_t'(DIGITS))
            lit_digit_chk: assert (seg != SEG_OFF);
    end

endmodule

// File: rtl/aux_flags.sv
module aux_flags
    import seg_counter_pkg::*;
#(
    parameter int MODULUS = DIGITS
) (
    input  logic   clk,
    input  logic   rst,
    input  digit_t cnt,
    output logic   div10,
    output logic   not_two
);
    localparam digit_t HALF = digit_t'(MODULUS / 2);

    always_comb begin
        div10   = (cnt < HALF);
        not_two = (cnt != digit_t'(2));
    end

    // R7
    div_rise_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(div10) |-> cnt == '0);

    // R8
    not_two_single_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(not_two) |-> $past(cnt) == digit_t'(1) || $past(cnt) == digit_t'(2) || $past(rst));

endmodule

// File: rtl/decade_seg_counter.sv
module decade_seg_counter
    import seg_counter_pkg::*;
#(
    parameter int MODULUS = DIGITS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       freeze,
    input  logic       disp_on,
    output logic [6:0] seg,
    output logic       disp_on_q,
    output logic       div10,
    output logic       not_two
);
    digit_t cnt;
    seg_t   seg_s;

    digit_counter #(.MODULUS(MODULUS)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .freeze (freeze),
        .cnt    (cnt)
    );

    seg_encoder u_enc (
        .cnt     (cnt),
        .disp_on (disp_on),
        .seg     (seg_s)
    );

    aux_flags #(.MODULUS(MODULUS)) u_aux (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt),
        .div10   (div10),
        .not_two (not_two)
    );

    always_ff @(posedge clk) begin
        if (rst)
            disp_on_q <= 1'b0;
        else
            disp_on_q <= disp_on;
    end

    assign seg = seg_s;

    // R6
    enable_delay_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> disp_on_q == $past(disp_on));

    // R5
    blank_chk: assert property (@(posedge clk) !disp_on |-> seg == 7'h00);

endmodule

// File: tb/sim_decade_seg_counter.sv
`timescale 1ns/1ps
module sim_decade_seg_counter;
    logic       clk = 1'b0;
    logic       rst, freeze, disp_on;
    logic [6:0] seg;
    logic       disp_on_q, div10, not_two;

    int tests = 0;
    int fails = 0;
    int model = 0;
    logic model_enq = 1'b0;
    bit done = 0;

    always #5 clk = ~clk;

    decade_seg_counter u0 (
        .clk       (clk),
        .rst       (rst),
        .freeze    (freeze),
        .disp_on   (disp_on),
        .seg       (seg),
        .disp_on_q (disp_on_q),
        .div10     (div10),
        .not_two   (not_two)
    );

    function automatic logic [6:0] exp_seg(input int d);
        case (d)
            0: return 7'h3F;
            1: return 7'h06;
            2: return 7'h5B;
            3: return 7'h4F;
            4: return 7'h66;
            5: return 7'h6D;
            6: return 7'h7D;
            7: return 7'h07;
            8: return 7'h7F;
            default: return 7'h6F;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (digit %0d)", req, act, exp, model);
        end
    endtask

    task automatic check_all();
        chk("R4/R5 seg", int'(seg), disp_on ? int'(exp_seg(model)) : 0);
        chk("R7 div10", int'(div10), (model <= 4) ? 1 : 0);
        chk("R8 not_two", int'(not_two), (model == 2) ? 0 : 1);
        chk("R6 disp_on_q", int'(disp_on_q), int'(model_enq));
    endtask

    task automatic step(input logic r, input logic f, input logic e);
        @(negedge clk);
        rst = r; freeze = f; disp_on = e;
        @(posedge clk);
        if (r) model = 0;
        else if (!f) model = (model + 1) % 10;
        model_enq = r ? 1'b0 : e;
        #1;
        check_all();
    endtask

    initial begin
        rst = 1'b1; freeze = 1'b0; disp_on = 1'b1;
        // R2: reset state
        step(1, 0, 1);
        step(1, 0, 1);
        chk("R2 reset digit", int'(seg), 'h3F);
        // R1, R4: sweep through all digits, two and a half wraps
        for (int i = 0; i < 25; i++) step(0, 0, 1);
        // R3: freeze holds the digit
        for (int i = 0; i < 4; i++) step(0, 1, 1);
        // R5: blank while counting, count continues
        for (int i = 0; i < 12; i++) step(0, 0, 0);
        step(0, 0, 1);
        // R6: toggle enable every cycle
        for (int i = 0; i < 10; i++) step(0, i % 3 == 0, i[0]);
        // R2: reset wins over freeze
        step(0, 0, 1);
        step(1, 1, 1);
        chk("R2 reset over freeze", int'(seg), 'h3F);
        // R1: walk to 9 and check wrap to 0
        for (int i = 0; i < 9; i++) step(0, 0, 1);
        chk("R1 at nine", int'(seg), 'h6F);
        step(0, 0, 1);
        chk("R1 wrap to zero", int'(seg), 'h3F);
        // mixed sweep over all input combinations
        for (int i = 0; i < 64; i++) step(i % 17 == 0, i[1] & i[2], ~i[3]);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule